// File: doc/BRIEF.md
# Address Translation Buffer with Kernel Window Bypass

This block turns 32-bit virtual addresses from one load/store port into physical addresses. It splits each address into a page number in the upper bits and a 12-bit byte offset in the lower bits. It then compares the page number with a small fully associative set of mappings, and builds the physical address from the matched frame number and the unchanged offset. Every lookup gives a registered response one clock after the request, carrying the physical address, a miss flag, a fault flag and the write strobe toward memory. The strobe is forced low whenever the access misses or faults, so a bad store never reaches memory.

Addresses whose two top bits are `10` (0x8000_0000 through 0xBFFF_FFFF) form a fixed kernel window. The window skips the lookup entirely: the two top bits are dropped, so the access lands in the bottom gigabyte of physical memory. It never misses, but only supervisor mode may use it. Each mapping carries a process tag that must equal the current process tag, unless the mapping is marked global. It also carries a writable bit and a user-access bit.

An external miss handler installs mappings through a refill port. A round-robin pointer picks the slot to overwrite. A flush strobe drops every mapping. On each miss or fault, the block captures the offending virtual address and a cause code for the handler to read.

Top module: `xlat_buffer`

## Requirements
- R1: On a hit, `rsp_paddr` is the matched entry's frame number in bits [31:12], joined with `req_vaddr[11:0]` passed through unchanged in bits [11:0].
- R2: A lookup outside the kernel window for which no valid entry matches gives `rsp_miss`=1, `rsp_fault`=0 and `rsp_paddr`=0. The miss and fault flags are never both high.
- R3: An entry matches only when its page number equals `req_vaddr[31:12]` and either its process tag equals `cur_asid` or its global bit is set. When several entries match, the lowest slot wins.
- R4: A supervisor access with `req_vaddr[31:30]`=2'b10 gives `rsp_paddr` = {2'b00, `req_vaddr[29:0]`} with no miss and no fault, even when no entry is valid.
- R5: A user-mode access (`sup_mode`=0) to the kernel window, or to a hit entry whose user bit is 0, raises `rsp_fault` with cause 2'b11 and `rsp_paddr`=0.
- R6: A write (`req_we`=1) that hits an entry whose writable bit is 0, and does not raise R5, raises `rsp_fault` with cause 2'b10. A read of the same entry hits.
- R7: `rsp_we` equals the request's `req_we` on a clean translation, and is 0 whenever the response misses or faults.
- R8: A request accepted at a clock edge gives `rsp_valid`=1 after exactly that edge. With no request, `rsp_valid`, `rsp_we`, `rsp_miss` and `rsp_fault` are 0.
- R9: Each refill writes the slot under a round-robin pointer that advances by one and wraps after the last slot. The refill after 16 fills evicts the oldest mapping.
- R10: In a cycle with `fill_valid` or `flush` high, any request in that cycle is dropped: no response follows.
- R11: `flush` invalidates every entry and returns the round-robin pointer to slot 0. Flush takes precedence over a refill in the same cycle.
- R12: On each miss or fault, `exc_vaddr` captures the request address and `exc_cause` captures the cause (01 miss, 10 write to read-only page, 11 privilege violation). Both hold their values otherwise.
- R13: After reset, every output is 0 and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_mode | input | 1 | 1 = supervisor, 0 = user |
| cur_asid | input | 8 | Process tag of the running program |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_we | input | 1 | Request is a store |
| fill_valid | input | 1 | Install one mapping |
| fill_vpn | input | 20 | Page number of the new mapping |
| fill_asid | input | 8 | Process tag of the new mapping |
| fill_ppn | input | 20 | Frame number of the new mapping |
| fill_global | input | 1 | Mapping matches any process tag |
| fill_writable | input | 1 | Mapping permits stores |
| fill_user | input | 1 | Mapping is reachable from user mode |
| flush | input | 1 | Invalidate all mappings |
| rsp_valid | output | 1 | Registered response present |
| rsp_paddr | output | 32 | Physical address, 0 on miss or fault |
| rsp_we | output | 1 | Write strobe toward memory |
| rsp_miss | output | 1 | No matching mapping |
| rsp_fault | output | 1 | Protection fault |
| exc_vaddr | output | 32 | Last faulting virtual address |
| exc_cause | output | 2 | Last fault cause |

## Verification
The bench builds the block with its default parameters: 16 slots, 4 KiB pages, 8-bit process tags and 20-bit frame numbers. With 16 slots, a run of seventeen refills after a flush brings the pointer wraparound within reach. It also shows whether the flush reset the pointer, because a pointer left anywhere else would evict a different mapping. The random phase draws page numbers from a pool of six, over two process tags and a mix of permission bits. This keeps duplicate mappings, lowest-slot priority and refill/lookup collisions frequent enough to be covered.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_MISS = 2'b01,
        CAUSE_RO   = 2'b10,
        CAUSE_PRIV = 2'b11
    } cause_e;

    // top two address bits that select the untranslated kernel window
    localparam logic [1:0] WIN_TAG = 2'b10;

endpackage

// File: rtl/xlat_store.sv
`timescale 1ns/1ps
module xlat_store #(
    parameter int N      = 16,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PPN_W  = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        fill_valid,
    input  logic [VPN_W-1:0]            fill_vpn,
    input  logic [ASID_W-1:0]           fill_asid,
    input  logic [PPN_W-1:0]            fill_ppn,
    input  logic                        fill_global,
    input  logic                        fill_writable,
    input  logic                        fill_user,
    output logic [N-1:0]                ent_valid,
    output logic [N-1:0]                ent_global,
    output logic [N-1:0]                ent_writable,
    output logic [N-1:0]                ent_user,
    output logic [N-1:0][VPN_W-1:0]     ent_vpn,
    output logic [N-1:0][ASID_W-1:0]    ent_asid,
    output logic [N-1:0][PPN_W-1:0]     ent_ppn
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        logic [N-1:0]             valid;
        logic [N-1:0]             global;
        logic [N-1:0]             writable;
        logic [N-1:0]             user;
        logic [N-1:0][VPN_W-1:0]  vpn;
        logic [N-1:0][ASID_W-1:0] asid;
        logic [N-1:0][PPN_W-1:0]  ppn;
        logic [IDX_W-1:0]         ptr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.valid = '0;
            st_d.ptr   = '0;
        end else if (fill_valid) begin
            st_d.valid[st_q.ptr]    = 1'b1;
            st_d.global[st_q.ptr]   = fill_global;
            st_d.writable[st_q.ptr] = fill_writable;
            st_d.user[st_q.ptr]     = fill_user;
            st_d.vpn[st_q.ptr]      = fill_vpn;
            st_d.asid[st_q.ptr]     = fill_asid;
            st_d.ppn[st_q.ptr]      = fill_ppn;
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent_valid    = st_q.valid;
    assign ent_global   = st_q.global;
    assign ent_writable = st_q.writable;
    assign ent_user     = st_q.user;
    assign ent_vpn      = st_q.vpn;
    assign ent_asid     = st_q.asid;
    assign ent_ppn      = st_q.ppn;

endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match #(
    parameter int N      = 16,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic [VPN_W-1:0]         look_vpn,
    input  logic [ASID_W-1:0]        look_asid,
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0]             ent_global,
    input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    output logic                     hit,
    output logic [N-1:0]             hit_sel
);

    logic [N-1:0] raw;

    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        assign raw[gi] = ent_valid[gi]
                      && (ent_vpn[gi] == look_vpn)
                      && (ent_global[gi] || (ent_asid[gi] == look_asid));
    end

    // keep only the lowest matching slot
    always_comb begin
        logic found;
        found   = 1'b0;
        hit_sel = '0;
        for (int i = 0; i < N; i++) begin
            if (raw[i] && !found) begin
                hit_sel[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign hit = |raw;

endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer #(
    parameter int N      = 16,
    parameter int VA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int ASID_W = 8,
    parameter int PPN_W  = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sup_mode,
    input  logic [ASID_W-1:0]         cur_asid,
    input  logic                      req_valid,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic                      req_we,
    input  logic                      fill_valid,
    input  logic [VA_W-OFF_W-1:0]     fill_vpn,
    input  logic [ASID_W-1:0]         fill_asid,
    input  logic [PPN_W-1:0]          fill_ppn,
    input  logic                      fill_global,
    input  logic                      fill_writable,
    input  logic                      fill_user,
    input  logic                      flush,
    output logic                      rsp_valid,
    output logic [PPN_W+OFF_W-1:0]    rsp_paddr,
    output logic                      rsp_we,
    output logic                      rsp_miss,
    output logic                      rsp_fault,
    output logic [VA_W-1:0]           exc_vaddr,
    output logic [1:0]                exc_cause
);

    import xlat_pkg::*;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int WIN_W = VA_W - 2;

    logic [N-1:0]             ent_valid, ent_global, ent_writable, ent_user;
    logic [N-1:0][VPN_W-1:0]  ent_vpn;
    logic [N-1:0][ASID_W-1:0] ent_asid;
    logic [N-1:0][PPN_W-1:0]  ent_ppn;
    logic                     hit;
    logic [N-1:0]             hit_sel;

    xlat_store #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .fill_valid    (fill_valid),
        .fill_vpn      (fill_vpn),
        .fill_asid     (fill_asid),
        .fill_ppn      (fill_ppn),
        .fill_global   (fill_global),
        .fill_writable (fill_writable),
        .fill_user     (fill_user),
        .ent_valid     (ent_valid),
        .ent_global    (ent_global),
        .ent_writable  (ent_writable),
        .ent_user      (ent_user),
        .ent_vpn       (ent_vpn),
        .ent_asid      (ent_asid),
        .ent_ppn       (ent_ppn)
    );

    xlat_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
        .look_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .look_asid  (cur_asid),
        .ent_valid  (ent_valid),
        .ent_global (ent_global),
        .ent_vpn    (ent_vpn),
        .ent_asid   (ent_asid),
        .hit        (hit),
        .hit_sel    (hit_sel)
    );

    // one-hot select of the winning slot's frame and permissions
    logic [PPN_W-1:0] sel_ppn;
    logic             sel_wr, sel_user;

    always_comb begin
        sel_ppn  = '0;
        sel_wr   = 1'b0;
        sel_user = 1'b0;
        for (int i = 0; i < N; i++) begin
            sel_ppn  = sel_ppn  | (ent_ppn[i] & {PPN_W{hit_sel[i]}});
            sel_wr   = sel_wr   | (ent_writable[i] & hit_sel[i]);
            sel_user = sel_user | (ent_user[i] & hit_sel[i]);
        end
    end

    typedef struct packed {
        logic             rsp_valid;
        logic [PA_W-1:0]  paddr;
        logic             we;
        logic             miss;
        logic             fault;
        logic [VA_W-1:0]  exc_va;
        cause_e           exc_cause;
    } resp_t;

    resp_t rs_d, rs_q;

    always_comb begin
        logic   lookup_en;
        logic   in_window;
        cause_e cause;

        rs_d           = rs_q;
        rs_d.rsp_valid = 1'b0;
        rs_d.paddr     = '0;
        rs_d.we        = 1'b0;
        rs_d.miss      = 1'b0;
        rs_d.fault     = 1'b0;

        lookup_en = req_valid && !fill_valid && !flush;
        in_window = (req_vaddr[VA_W-1 -: 2] == WIN_TAG);
        cause     = CAUSE_NONE;

        if (lookup_en) begin
            rs_d.rsp_valid = 1'b1;
            if (in_window) begin
                if (sup_mode) begin
                    rs_d.paddr = PA_W'(req_vaddr[WIN_W-1:0]);
                    rs_d.we    = req_we;
                end else begin
                    cause = CAUSE_PRIV;
                end
            end else if (!hit) begin
                cause = CAUSE_MISS;
            end else if (!sup_mode && !sel_user) begin
                cause = CAUSE_PRIV;
            end else if (req_we && !sel_wr) begin
                cause = CAUSE_RO;
            end else begin
                rs_d.paddr = {sel_ppn, req_vaddr[OFF_W-1:0]};
                rs_d.we    = req_we;
            end

            if (cause != CAUSE_NONE) begin
                rs_d.miss      = (cause == CAUSE_MISS);
                rs_d.fault     = (cause != CAUSE_MISS);
                rs_d.exc_va    = req_vaddr;
                rs_d.exc_cause = cause;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rsp_valid = rs_q.rsp_valid;
    assign rsp_paddr = rs_q.paddr;
    assign rsp_we    = rs_q.we;
    assign rsp_miss  = rs_q.miss;
    assign rsp_fault = rs_q.fault;
    assign exc_vaddr = rs_q.exc_va;
    assign exc_cause = rs_q.exc_cause;

endmodule

// File: rtl/xlat_buffer_chk.sv
`timescale 1ns/1ps
module xlat_buffer_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            req_we,
    input logic            fill_valid,
    input logic            flush,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_we,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic [1:0]      exc_cause
);

    import xlat_pkg::*;

    logic accepted;
    assign accepted = req_valid && !fill_valid && !flush;

    p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss && !rsp_fault)
        |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_miss && rsp_fault));

    p_window_nomiss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && req_vaddr[VA_W-1 -: 2] == WIN_TAG) |=> !rsp_miss);

    p_we_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_miss || rsp_fault)) |-> !rsp_we);

    p_read_no_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && !req_we) |=> !rsp_we);

    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> rsp_valid);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_we && !rsp_miss && !rsp_fault));

    p_refill_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || flush) |=> !rsp_valid);

    p_miss_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> exc_cause == 2'b01);

    p_cause_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && (rsp_miss || rsp_fault)) |-> $stable(exc_cause));

endmodule

bind xlat_buffer xlat_buffer_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tb_xlat_buffer.sv
`timescale 1ns/1ps
module tb_xlat_buffer;

    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sup_mode;
    logic [7:0]  cur_asid;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_we;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [7:0]  fill_asid;
    logic [19:0] fill_ppn;
    logic        fill_global, fill_writable, fill_user;
    logic        flush;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_we, rsp_miss, rsp_fault;
    logic [31:0] exc_vaddr;
    logic [1:0]  exc_cause;

    always #10 clk = ~clk;

    xlat_buffer dut (
        .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .cur_asid(cur_asid),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_we(req_we),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_ppn(fill_ppn), .fill_global(fill_global),
        .fill_writable(fill_writable), .fill_user(fill_user), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_we(rsp_we),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .exc_vaddr(exc_vaddr), .exc_cause(exc_cause)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural reference state
    bit          m_valid [NE];
    logic [19:0] m_vpn   [NE];
    logic [7:0]  m_asid  [NE];
    logic [19:0] m_ppn   [NE];
    bit          m_g [NE], m_w [NE], m_u [NE];
    int          m_ptr = 0;
    logic [31:0] m_exc_va = '0;
    logic [1:0]  m_exc_c  = '0;

    task automatic cmp(input string rq, input string tag, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (scenario %s) %s act=%h exp=%h", rq, tag, nm, act, exp);
        end
    endtask

    task automatic go_idle();
        req_valid = 0; req_we = 0; req_vaddr = '0;
        fill_valid = 0; flush = 0;
    endtask

    task automatic set_req(input logic [31:0] va, input bit we, input bit sup, input logic [7:0] asid);
        req_valid = 1; req_vaddr = va; req_we = we; sup_mode = sup; cur_asid = asid;
        fill_valid = 0; flush = 0;
    endtask

    task automatic set_fill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] ppn,
                            input bit g, input bit w, input bit u);
        fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn;
        fill_global = g; fill_writable = w; fill_user = u;
        req_valid = 0; flush = 0;
    endtask

    // advance one cycle, predict the response of the inputs just taken, compare
    task automatic tick(input string tag);
        logic        ev, em, ef, ewe;
        logic [31:0] ep;
        logic [1:0]  c;
        int          hi;
        @(posedge clk);
        @(negedge clk);
        ev = 0; em = 0; ef = 0; ewe = 0; ep = '0; c = 2'b00;
        if (flush) begin
            for (int i = 0; i < NE; i++) m_valid[i] = 0;
            m_ptr = 0;
        end else if (fill_valid) begin
            m_valid[m_ptr] = 1; m_vpn[m_ptr] = fill_vpn; m_asid[m_ptr] = fill_asid;
            m_ppn[m_ptr] = fill_ppn; m_g[m_ptr] = fill_global;
            m_w[m_ptr] = fill_writable; m_u[m_ptr] = fill_user;
            m_ptr = (m_ptr + 1) % NE;
        end else if (req_valid) begin
            ev = 1;
            if (req_vaddr[31:30] == 2'b10) begin
                if (sup_mode) begin ep = {2'b00, req_vaddr[29:0]}; ewe = req_we; end
                else c = 2'b11;
            end else begin
                hi = -1;
                for (int i = 0; i < NE; i++)
                    if (hi < 0 && m_valid[i] && m_vpn[i] == req_vaddr[31:12]
                        && (m_g[i] || m_asid[i] == cur_asid)) hi = i;
                if (hi < 0)                       c = 2'b01;
                else if (!sup_mode && !m_u[hi])   c = 2'b11;
                else if (req_we && !m_w[hi])      c = 2'b10;
                else begin ep = {m_ppn[hi], req_vaddr[11:0]}; ewe = req_we; end
            end
            if (c != 2'b00) begin
                em = (c == 2'b01); ef = !em;
                m_exc_va = req_vaddr; m_exc_c = c;
            end
        end
        cmp("R8",  tag, "rsp_valid", 32'(rsp_valid), 32'(ev));
        cmp("R1",  tag, "rsp_paddr", rsp_paddr, ep);
        cmp("R2",  tag, "rsp_miss",  32'(rsp_miss), 32'(em));
        cmp("R5",  tag, "rsp_fault", 32'(rsp_fault), 32'(ef));
        cmp("R7",  tag, "rsp_we",    32'(rsp_we), 32'(ewe));
        cmp("R12", tag, "exc_vaddr", exc_vaddr, m_exc_va);
        cmp("R12", tag, "exc_cause", 32'(exc_cause), 32'(m_exc_c));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_valid[i] = 0; m_vpn[i] = '0; m_asid[i] = '0; m_ppn[i] = '0;
            m_g[i] = 0; m_w[i] = 0; m_u[i] = 0;
        end
        rst_n = 0; sup_mode = 0; cur_asid = '0;
        fill_vpn = '0; fill_asid = '0; fill_ppn = '0;
        fill_global = 0; fill_writable = 0; fill_user = 0;
        go_idle();
        repeat (3) @(negedge clk);
        // R13 reset state
        cmp("R13", "reset", "rsp_valid", 32'(rsp_valid), 0);
        cmp("R13", "reset", "rsp_paddr", rsp_paddr, 0);
        cmp("R13", "reset", "exc_cause", 32'(exc_cause), 0);
        rst_n = 1;
        tick("R13");

        // R2 miss on empty buffer, R13 no entry valid after reset
        set_req(32'h0040_1234, 0, 0, 8'd5); tick("R2");
        set_req(32'h0000_0ABC, 1, 1, 8'd5); tick("R13");

        // R9 refill, R1 hit translation, R7 store strobe
        set_fill(20'h00401, 8'd5, 20'h12345, 0, 1, 1); tick("R9");
        set_req(32'h0040_1234, 0, 0, 8'd5); tick("R1");
        set_req(32'h0040_1FFF, 1, 0, 8'd5); tick("R7");
        go_idle(); tick("R12");

        // R3 process tag and global mappings
        set_req(32'h0040_1010, 0, 0, 8'd6); tick("R3");
        set_fill(20'h00777, 8'd1, 20'hABCDE, 1, 1, 1); tick("R9");
        set_req(32'h0077_7321, 1, 0, 8'd9); tick("R3");
        set_fill(20'h00401, 8'd6, 20'h55555, 0, 1, 1); tick("R9");
        set_req(32'h0040_1444, 0, 0, 8'd6); tick("R3");
        set_fill(20'h00401, 8'd6, 20'h66666, 0, 1, 1); tick("R9");
        set_req(32'h0040_1444, 0, 0, 8'd6); tick("R3");

        // R6 read-only page
        set_fill(20'h00100, 8'd5, 20'h0BEEF, 0, 0, 1); tick("R9");
        set_req(32'h0010_0008, 1, 0, 8'd5); tick("R6");
        set_req(32'h0010_0008, 0, 0, 8'd5); tick("R6");
        set_req(32'h0010_0010, 1, 1, 8'd5); tick("R6");

        // R5 supervisor-only page
        set_fill(20'h00200, 8'd5, 20'h0CAFE, 0, 1, 0); tick("R9");
        set_req(32'h0020_0FF0, 0, 0, 8'd5); tick("R5");
        set_req(32'h0020_0FF0, 1, 1, 8'd5); tick("R5");
        go_idle(); tick("R12");

        // R4 kernel window, R5 user access to it
        set_req(32'h9234_5678, 1, 1, 8'd3); tick("R4");
        set_req(32'hBFFF_FFFF, 0, 1, 8'd3); tick("R4");
        set_req(32'h8000_0000, 1, 1, 8'd3); tick("R4");
        set_req(32'hA000_0040, 1, 0, 8'd3); tick("R5");

        // R10 refill or flush beats a lookup in the same cycle
        set_fill(20'h00300, 8'd5, 20'h00300, 0, 1, 1);
        req_valid = 1; req_vaddr = 32'h0030_0000; tick("R10");
        go_idle(); flush = 1; req_valid = 1; req_vaddr = 32'h0040_1234; tick("R10");
        go_idle(); tick("R10");

        // R11 flush empties the buffer and rewinds the pointer
        set_req(32'h0077_7000, 0, 1, 8'd1); tick("R11");
        set_fill(20'h00AAA, 8'd5, 20'h00AAA, 0, 1, 1);
        flush = 1; tick("R11");
        go_idle();
        set_req(32'h00AA_A000, 0, 1, 8'd5); tick("R11");

        // R9 wraparound: 17 fills evict the first
        for (int i = 0; i < 16; i++) begin
            set_fill(20'h00500 + 20'(i), 8'd2, 20'h70000 + 20'(i), 0, 1, 1); tick("R9");
        end
        set_fill(20'h00999, 8'd2, 20'h79999, 0, 1, 1); tick("R9");
        set_req(32'h0050_0004, 0, 0, 8'd2); tick("R9");
        set_req(32'h0050_1004, 0, 0, 8'd2); tick("R9");
        set_req(32'h0099_9004, 1, 0, 8'd2); tick("R11");

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 40);
            if (r == 0) begin
                go_idle(); flush = 1;
                if ($urandom % 2 == 1) fill_valid = 1;
            end else if (r < 8) begin
                set_fill(20'h00400 + 20'($urandom % 6), 8'($urandom % 2 + 1),
                         20'($urandom), 1'($urandom % 4 == 0),
                         1'($urandom), 1'($urandom % 4 != 0));
                if ($urandom % 4 == 0) begin req_valid = 1; req_vaddr = 32'($urandom); end
            end else if (r < 34) begin
                if ($urandom % 8 == 0)
                    set_req({2'b10, 30'($urandom)}, 1'($urandom), 1'($urandom), 8'd1);
                else
                    set_req({20'h00400 + 20'($urandom % 6), 12'($urandom)},
                            1'($urandom), 1'($urandom), 8'($urandom % 2 + 1));
            end else begin
                go_idle();
            end
            tick("R3");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule